// File: doc/BRIEF.md
# Bus Channel Fault and Enable Controller

This block keeps one 8-bit enable and status register for each channel of a multi-channel two-wire sensor bus master. It turns raw protection signals into fault responses. A thermal-limit flag from a channel driver, or from either of the two pseudo-bus switches that exist only on channel zero, counts only after it has stayed high for a fixed filter time. An over-current that shows up in two signalling frames in a row shuts the channel drivers down. Each fault clears a different set of register bits, and the set is wider on channel zero than on the other channels.

The host writes and reads the registers through a simple synchronous port. Downstream logic uses four kinds of output: the driver enable of each channel, the closed state of the two switches, and one-cycle buffer-reset and transfer-abort pulses. The fault flags are sticky. The host clears a flag by writing a zero to it. Once the switches have opened, they stay open until the host writes a one to the switch bit again.

Top module: `bus_fault_ctl`

## Requirements
- R1: After reset, every register bit reads zero, every driver enable is low, both switches are open, and no pulse is output.
- R2: Register layout. Bit 0 is the enable. Bit 1 is the low switch and bit 2 is the high switch; both exist on channel zero only and read as zero on every other channel. Bit 6 is the over-current shutdown flag and bit 7 is the thermal flag. Bits 5 to 3 always read zero. The driver enable of a channel is high only when its enable bit is one and both of its fault flags are zero.
- R3: A channel thermal input counts only after it has been sampled high on FILT_US*CLK_MHZ consecutive clock edges (200 with the default parameters, which is 4 µs at 50 MHz). A shorter run changes nothing.
- R4: A counted channel thermal event does four things: it sets the thermal flag, clears the enable, drops the driver enable, and outputs one buffer-reset pulse and one transfer-abort pulse. The over-current flag keeps its value.
- R5: A thermal event on channel zero also opens both switches and clears both switch bits.
- R6: A switch thermal input goes through the same filter. Its event opens both switches and clears both switch bits. The enable, the fault flags and the driver enables do not change, and no pulse is output.
- R7: Suppose a channel has its enable set and its signalling-mode input high, and an over-current is sampled at frame_end in two consecutive frames. At the second frame the over-current flag is set, the enable is cleared, and one buffer-reset pulse and one transfer-abort pulse are output. The thermal flag does not change.
- R8: At frame_end, a frame counts toward an over-current run only if it has the over-current, signalling mode and the enable all present. Any other frame breaks the run.
- R9: An over-current shutdown on channel zero also opens both switches and clears both switch bits.
- R10: Both fault flags are sticky. Writing a one to a flag leaves it unchanged. Writing a zero to a flag clears it.
- R11: Clearing the channel-zero enable, whether by a write or by a fault, opens both switches. A write of one to a switch bit closes that switch only if, after the write, the enable is one and both fault flags are zero. In every other case the bit stays zero.
- R12: Each fault event produces exactly one buffer-reset pulse and one transfer-abort pulse, each one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CW | Channel selected for the write |
| wr_data | input | 8 | Write data |
| rd_ch | input | CW | Channel selected for the read |
| rd_data | output | 8 | Register contents of the selected channel |
| therm_raw | input | NCH | Raw thermal-limit flag of each channel driver |
| sw_therm_hi | input | 1 | Raw thermal-limit flag of the high switch |
| sw_therm_lo | input | 1 | Raw thermal-limit flag of the low switch |
| oc_flag | input | NCH | Over-current flag of each channel, sampled at frame_end |
| sig_mode | input | NCH | High while the channel is in signalling mode |
| frame_end | input | 1 | Frame-boundary strobe |
| drv_en | output | NCH | Bus driver enable of each channel |
| sw_hi_closed | output | 1 | High switch closed |
| sw_lo_closed | output | 1 | Low switch closed |
| buf_rst | output | NCH | One-cycle buffer and pointer reset pulse |
| xfer_abort | output | NCH | One-cycle transfer abort pulse |

## Verification
The hardest case to reach is the over-current run. Its result depends on the order of frames, on which frames fall in signalling mode, and on the enable bit, which the shutdown itself clears. To cover it, the stimulus first re-arms one channel and breaks any open run with a clean frame. It then sweeps all 64 combinations of over-current and signalling mode across three frames. For each combination the bench predicts the flag and the pulse count from the rule that shutdown needs two adjacent qualifying frames. The thermal filter is probed with runs one clock shorter than the limit and exactly at the limit.

// File: rtl/bus_fault_ctl.sv
module bus_fault_ctl #(
  parameter int NCH = 4,
  parameter int CLK_MHZ = 50,
  parameter int FILT_US = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FILT = CLK_MHZ * FILT_US,
  localparam int FW = $clog2(FILT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_ch,
  input  logic [7:0]     wr_data,
  input  logic [CW-1:0]  rd_ch,
  output logic [7:0]     rd_data,
  input  logic [NCH-1:0] therm_raw,
  input  logic           sw_therm_hi,
  input  logic           sw_therm_lo,
  input  logic [NCH-1:0] oc_flag,
  input  logic [NCH-1:0] sig_mode,
  input  logic           frame_end,
  output logic [NCH-1:0] drv_en,
  output logic           sw_hi_closed,
  output logic           sw_lo_closed,
  output logic [NCH-1:0] buf_rst,
  output logic [NCH-1:0] xfer_abort
);

  logic [NCH-1:0] en, ts, isdd, oc_prev;
  logic [NCH-1:0] en_n, ts_n, isdd_n, oc_prev_n;
  logic [NCH-1:0] oc_hit, oc_evt;
  logic [NCH+1:0] tl_raw, tl_evt;
  logic sw_hi, sw_lo, sw_hi_n, sw_lo_n, sw_ok, wr0;

  assign tl_raw = {sw_therm_lo, sw_therm_hi, therm_raw};

  for (genvar i = 0; i < NCH + 2; i++) begin : g_filt
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else if (!tl_raw[i]) cnt <= '0;
      else if (cnt != FW'(FILT)) cnt <= cnt + 1'b1;
    assign tl_evt[i] = tl_raw[i] && (cnt == FW'(FILT - 1));
  end

  assign oc_hit = {NCH{frame_end}} & sig_mode & oc_flag & en;
  assign oc_evt = oc_hit & oc_prev;
  assign wr0 = wr_en && (wr_ch == '0);

  always_comb begin
    en_n = en;
    ts_n = ts;
    isdd_n = isdd;
    oc_prev_n = oc_prev;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en && wr_ch == CW'(c)) begin
        en_n[c] = wr_data[0];
        ts_n[c] = ts[c] & wr_data[7];
        isdd_n[c] = isdd[c] & wr_data[6];
      end
      if (frame_end) oc_prev_n[c] = oc_hit[c] & ~oc_prev[c];
      if (oc_evt[c]) begin
        isdd_n[c] = 1'b1;
        en_n[c] = 1'b0;
      end
      if (tl_evt[c]) begin
        ts_n[c] = 1'b1;
        en_n[c] = 1'b0;
      end
    end
    sw_ok = en_n[0] & ~ts_n[0] & ~isdd_n[0] & ~tl_evt[NCH] & ~tl_evt[NCH+1];
    sw_hi_n = (wr0 ? wr_data[2] : sw_hi) & sw_ok;
    sw_lo_n = (wr0 ? wr_data[1] : sw_lo) & sw_ok;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= '0;
      ts <= '0;
      isdd <= '0;
      oc_prev <= '0;
      sw_hi <= 1'b0;
      sw_lo <= 1'b0;
      buf_rst <= '0;
      xfer_abort <= '0;
    end else begin
      en <= en_n;
      ts <= ts_n;
      isdd <= isdd_n;
      oc_prev <= oc_prev_n;
      sw_hi <= sw_hi_n;
      sw_lo <= sw_lo_n;
      buf_rst <= tl_evt[NCH-1:0] | oc_evt;
      xfer_abort <= tl_evt[NCH-1:0] | oc_evt;
    end

  assign drv_en = en & ~ts & ~isdd;
  assign sw_hi_closed = sw_hi;
  assign sw_lo_closed = sw_lo;

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_ch == CW'(c))
        rd_data = {ts[c], isdd[c], 3'b000, (c == 0) & sw_hi, (c == 0) & sw_lo, en[c]};
  end

  // R11
  sw_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hi || sw_lo) |-> (en[0] && !ts[0] && !isdd[0]));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R10
    ts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ts[c] && !(wr_en && wr_ch == CW'(c) && !wr_data[7])) |=> ts[c]);
    // R4
    ts_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts[c]) |-> (!drv_en[c] && buf_rst[c] && xfer_abort[c]));
    // R7
    isdd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isdd[c]) |-> $past(frame_end && oc_flag[c] && sig_mode[c] && en[c]));
    // R12
    pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rst[c] |-> !en[c]);
  end

endmodule

// File: tb/bus_fault_ctl_bench.sv
`timescale 1ns/1ps
module bus_fault_ctl_bench;
  localparam int NCH = 4;
  localparam int FILT = 200;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, frame_end = 0, sw_therm_hi = 0, sw_therm_lo = 0;
  logic [1:0] wr_ch = 0, rd_ch = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [NCH-1:0] therm_raw = 0, oc_flag = 0, sig_mode = 0;
  logic [NCH-1:0] drv_en, buf_rst, xfer_abort;
  logic sw_hi_closed, sw_lo_closed;
  int checks = 0, fails = 0;
  int rst_cnt [NCH];
  int ab_cnt [NCH];
  bit done = 0;

  always #10 clk = ~clk;

  bus_fault_ctl u_bus_fault_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .therm_raw(therm_raw),
    .sw_therm_hi(sw_therm_hi), .sw_therm_lo(sw_therm_lo), .oc_flag(oc_flag),
    .sig_mode(sig_mode), .frame_end(frame_end), .drv_en(drv_en),
    .sw_hi_closed(sw_hi_closed), .sw_lo_closed(sw_lo_closed),
    .buf_rst(buf_rst), .xfer_abort(xfer_abort));

  initial for (int c = 0; c < NCH; c++) begin rst_cnt[c] = 0; ab_cnt[c] = 0; end
  always @(negedge clk)
    for (int c = 0; c < NCH; c++) begin
      if (buf_rst[c]) rst_cnt[c]++;
      if (xfer_abort[c]) ab_cnt[c]++;
    end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int ch, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_ch = 2'(ch); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, int ch, int exp);
    rd_ch = 2'(ch); #1;
    chk(req, rd_data, exp);
  endtask

  task automatic therm(int ch, int len);
    @(negedge clk);
    if (ch < NCH) therm_raw[ch] = 1; else if (ch == NCH) sw_therm_hi = 1; else sw_therm_lo = 1;
    repeat (len) @(negedge clk);
    therm_raw = 0; sw_therm_hi = 0; sw_therm_lo = 0;
    @(negedge clk);
  endtask

  task automatic frame(int ch, bit oc, bit sg);
    @(negedge clk); frame_end = 1; oc_flag[ch] = oc; sig_mode[ch] = sg;
    @(negedge clk); frame_end = 0; oc_flag = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++) rd_chk("R1", c, 0);
    chk("R1 drv", drv_en, 0);
    chk("R1 sw", {sw_hi_closed, sw_lo_closed}, 0);
    chk("R1 pulse", rst_cnt[0] + rst_cnt[1] + rst_cnt[2] + rst_cnt[3], 0);

    // R2 layout: unused and switch bits absent on channel 1
    wr(1, 8'h3F);
    rd_chk("R2", 1, 8'h01);
    chk("R2 drv", drv_en[1], 1);
    wr(0, 8'h07);
    rd_chk("R2 ch0", 0, 8'h07);
    chk("R2 sw", {sw_hi_closed, sw_lo_closed}, 2'b11);

    // R11 host clears enable; switch write with enable zero ignored
    wr(0, 8'h06);
    rd_chk("R11", 0, 8'h00);
    chk("R11 sw", {sw_hi_closed, sw_lo_closed}, 0);
    wr(0, 8'h05);
    rd_chk("R11 hi", 0, 8'h05);
    chk("R11 hi out", {sw_hi_closed, sw_lo_closed}, 2'b10);

    // R3 filter: one clock short leaves channel 2 untouched
    wr(2, 8'h01);
    for (int l = FILT - 3; l < FILT; l++) therm(2, l);
    rd_chk("R3 short", 2, 8'h01);
    chk("R3 short pulse", rst_cnt[2], 0);
    therm(2, FILT);
    // R4 thermal effects
    rd_chk("R4", 2, 8'h80);
    chk("R4 drv", drv_en[2], 0);
    chk("R12 rst", rst_cnt[2], 1);
    chk("R12 abort", ab_cnt[2], 1);
    therm(2, FILT + 40);
    chk("R12 once", rst_cnt[2], 2);

    // R10 sticky
    wr(2, 8'hC1);
    rd_chk("R10 keep", 2, 8'h81);
    chk("R10 drv", drv_en[2], 0);
    wr(2, 8'h01);
    rd_chk("R10 clear", 2, 8'h01);
    chk("R10 drv on", drv_en[2], 1);

    // R6 switch thermal on each switch
    for (int s = NCH; s < NCH + 2; s++) begin
      wr(0, 8'h07);
      therm(s, FILT);
      rd_chk("R6", 0, 8'h01);
      chk("R6 sw", {sw_hi_closed, sw_lo_closed}, 0);
      chk("R6 drv", drv_en[0], 1);
      chk("R6 pulse", rst_cnt[0], 0);
    end

    // R5 thermal on channel zero opens switches
    wr(0, 8'h07);
    therm(0, FILT);
    rd_chk("R5", 0, 8'h80);
    chk("R5 sw", {sw_hi_closed, sw_lo_closed}, 0);
    // R11 switch write ignored while thermal flag set
    wr(0, 8'h87);
    rd_chk("R11 fault", 0, 8'h81);
    chk("R11 fault sw", {sw_hi_closed, sw_lo_closed}, 0);

    // R9 over-current shutdown on channel zero
    wr(0, 8'h07);
    frame(0, 1, 1);
    frame(0, 1, 1);
    rd_chk("R9", 0, 8'h40);
    chk("R9 sw", {sw_hi_closed, sw_lo_closed}, 0);

    // R8 enable zero: frames do not count
    wr(3, 8'h00);
    frame(3, 1, 1);
    frame(3, 1, 1);
    rd_chk("R8 en0", 3, 8'h00);

    // R7/R8 exhaustive three-frame sweep on channel 3
    for (int p = 0; p < 64; p++) begin
      bit q [3];
      bit exp_sd;
      int base;
      wr(3, 8'h01);
      frame(3, 0, 1);
      base = rst_cnt[3];
      for (int i = 0; i < 3; i++) begin
        q[i] = p[2*i] & p[2*i+1];
        frame(3, p[2*i], p[2*i+1]);
      end
      exp_sd = (q[0] & q[1]) | (q[1] & q[2]);
      rd_chk("R7 R8 sweep", 3, exp_sd ? 8'h40 : 8'h01);
      chk("R7 pulse", rst_cnt[3] - base, exp_sd ? 1 : 0);
      chk("R7 drv", drv_en[3], exp_sd ? 0 : 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule